// File: doc/BRIEF.md
# Bus Trigger Comparator Bank

This block watches the processor bus for a debug monitor. It holds ten match units. Each unit compares either the address bus or the data bus with a programmed value. A mask removes chosen bits from the comparison, and the unit applies one of four relational tests. The match also depends on the kind of access: instruction fetch, read, write, DMA, or a mix of these.

Each unit also has a combination vector. Unit i fires when every unit named in that vector matches in the same bus cycle. One unit can therefore act alone, or several units can be chained into an address-and-data condition. The fired flags come out one cycle after the bus cycle that caused them.

Software reaches the registers through a simple write strobe and a combinational read port. The bus side is observation only. `bus_valid` marks a bus cycle, and there is no back-pressure toward the bus: the bank never stalls what it watches and must accept every cycle as it comes.

Top module: `bus_trig_bank`

## Requirements
- R1: After reset every register reads zero and `trig_o` is all zero.
- R2: Unit i owns byte addresses 8*i to 8*i+7. Offset 0 holds the 20-bit compare value, offset 2 the 7-bit control word, offset 4 the 20-bit mask and offset 6 the 10-bit combination vector. Each register reads back what was written, truncated to its width and zero-extended.
- R3: A write to an odd address, or to an address at or above 8*N_UNITS, changes no register. A read of such an address returns zero.
- R4: Control bit 0 selects the compared bus: 0 selects the address bus and 1 the data bus.
- R5: Control bits 4:3 select the test of the masked bus value against the masked compare value: 00 equal, 01 bus greater, 10 bus less, 11 not equal. All tests are unsigned.
- R6: A mask bit set to 1 removes that bit from both operands before the test.
- R7: The access code is {ctl[6],ctl[5],ctl[2],ctl[1]}. A read is a cycle with `bus_write`=0. The codes mean: 0 fetch, 1 fetch hold (`bus_hold`), 2 no fetch, 3 any access, 4 no fetch and read, 5 no fetch and write, 6 read, 7 write, 8 no fetch and no DMA, 9 DMA, A no DMA, B write and no DMA, C no fetch and read and no DMA, D read and no DMA, E read and DMA, F write and DMA. A unit matches only when both the value test and the access code hold.
- R8: `trig_o[i]` fires when the combination vector of unit i is nonzero and every unit it names matches. An all-zero vector never fires.
- R9: `trig_o` is registered. It reflects the bus cycle presented one clock earlier, and it is zero after any clock in which `bus_valid` was low.
- R10: A register write and a bus cycle in the same clock are evaluated with the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register byte address |
| reg_wdata | input | 20 | Register write data |
| reg_rdata | output | 20 | Register read data (combinational) |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | 20 | Observed address bus |
| bus_data | input | 20 | Observed data bus |
| bus_fetch | input | 1 | Cycle is an instruction fetch |
| bus_hold | input | 1 | Fetch is being held |
| bus_write | input | 1 | 1 write, 0 read |
| bus_dma | input | 1 | Cycle is a DMA access |
| trig_o | output | 10 | Combined trigger, one per unit |

## Verification
Two events can land on the same clock: a register write that reprograms a unit, and a bus cycle that the same unit is judging. The bench creates this case directly. It retargets a unit's compare value while the bus shows the old value, and it expects the trigger to follow the old setting. The random phase also mixes writes into live bus traffic, and each cycle is scored against a reference model that applies a write only after it has evaluated that cycle. The second overlap is within the combination logic: several units must match in one cycle. It is tested with address and data units that match together and then with only one of them matching.

// File: rtl/bus_trig_pkg.sv
package bus_trig_pkg;

  localparam int CTL_W = 7;

  typedef enum logic [1:0] {
    CMP_EQ = 2'b00,
    CMP_GT = 2'b01,
    CMP_LT = 2'b10,
    CMP_NE = 2'b11
  } cmp_mode_e;

  // access-type decode: code = {ctl[6], ctl[5], ctl[2], ctl[1]}
  function automatic logic access_ok(input logic [3:0] code, input logic fetch,
                                     input logic hold, input logic wr, input logic dma);
    logic rd;
    rd = !wr;
    case (code)
      4'h0: access_ok = fetch;
      4'h1: access_ok = hold;
      4'h2: access_ok = !fetch;
      4'h3: access_ok = 1'b1;
      4'h4: access_ok = !fetch && rd;
      4'h5: access_ok = !fetch && wr;
      4'h6: access_ok = rd;
      4'h7: access_ok = wr;
      4'h8: access_ok = !fetch && !dma;
      4'h9: access_ok = dma;
      4'hA: access_ok = !dma;
      4'hB: access_ok = wr && !dma;
      4'hC: access_ok = !fetch && rd && !dma;
      4'hD: access_ok = rd && !dma;
      4'hE: access_ok = rd && dma;
      default: access_ok = wr && dma;
    endcase
  endfunction

endpackage

// File: rtl/btb_regs.sv
module btb_regs
  import bus_trig_pkg::*;
#(
  parameter int N_UNITS = 10,
  parameter int BUS_W   = 20,
  parameter int AW      = 7
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  we,
  input  logic [AW-1:0]                         addr,
  input  logic [BUS_W-1:0]                      wdata,
  output logic [BUS_W-1:0]                      rdata,
  output logic [N_UNITS-1:0][BUS_W-1:0]         val_o,
  output logic [N_UNITS-1:0][CTL_W-1:0]         ctl_o,
  output logic [N_UNITS-1:0][BUS_W-1:0]         msk_o,
  output logic [N_UNITS-1:0][N_UNITS-1:0]       comb_o
);
  localparam int UW = AW - 3;

  logic [UW-1:0] unit_idx;
  logic          in_map;

  assign unit_idx = addr[AW-1:3];
  assign in_map   = !addr[0] && (int'(unit_idx) < N_UNITS);

  for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
    logic sel;
    assign sel = we && in_map && (unit_idx == UW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        val_o[i]  <= '0;
        ctl_o[i]  <= '0;
        msk_o[i]  <= '0;
        comb_o[i] <= '0;
      end else if (sel) begin
        case (addr[2:1])
          2'd0: val_o[i]  <= wdata;
          2'd1: ctl_o[i]  <= wdata[CTL_W-1:0];
          2'd2: msk_o[i]  <= wdata;
          default: comb_o[i] <= wdata[N_UNITS-1:0];
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (in_map) begin
      for (int j = 0; j < N_UNITS; j++) begin
        if (unit_idx == UW'(j)) begin
          case (addr[2:1])
            2'd0: rdata = val_o[j];
            2'd1: rdata = BUS_W'(ctl_o[j]);
            2'd2: rdata = msk_o[j];
            default: rdata = BUS_W'(comb_o[j]);
          endcase
        end
      end
    end
  end

  // R3: unmapped writes leave all state untouched
  p_unmapped_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !in_map) |=> ($stable(val_o) && $stable(ctl_o) && $stable(msk_o) && $stable(comb_o)));

endmodule

// File: rtl/btb_match.sv
module btb_match
  import bus_trig_pkg::*;
#(
  parameter int BUS_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] bus_addr,
  input  logic [BUS_W-1:0] bus_data,
  input  logic             bus_fetch,
  input  logic             bus_hold,
  input  logic             bus_write,
  input  logic             bus_dma,
  input  logic [BUS_W-1:0] val,
  input  logic [CTL_W-1:0] ctl,
  input  logic [BUS_W-1:0] msk,
  output logic             hit
);
  logic [BUS_W-1:0] opd_bus, opd_val;
  logic             eq, gt, lt, rel;
  cmp_mode_e        mode;

  assign opd_bus = (ctl[0] ? bus_data : bus_addr) & ~msk;
  assign opd_val = val & ~msk;
  assign eq      = (opd_bus == opd_val);
  assign gt      = (opd_bus > opd_val);
  assign lt      = (opd_bus < opd_val);
  assign mode    = cmp_mode_e'(ctl[4:3]);

  always_comb begin
    case (mode)
      CMP_EQ:  rel = eq;
      CMP_GT:  rel = gt;
      CMP_LT:  rel = lt;
      default: rel = !eq;
    endcase
  end

  assign hit = rel && access_ok({ctl[6], ctl[5], ctl[2], ctl[1]},
                                bus_fetch, bus_hold, bus_write, bus_dma);

  // R5: exactly one relation holds between the masked operands
  p_rel_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({eq, gt, lt}) == 1);

  // R6: a full mask leaves nothing to differ
  p_full_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (&msk) |-> eq);

endmodule

// File: rtl/btb_combine.sv
module btb_combine #(
  parameter int N_UNITS = 10
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_valid,
  input  logic [N_UNITS-1:0]              hits,
  input  logic [N_UNITS-1:0][N_UNITS-1:0] comb,
  output logic [N_UNITS-1:0]              trig_o
);
  logic [N_UNITS-1:0] fire;

  for (genvar i = 0; i < N_UNITS; i++) begin : g_fire
    assign fire[i] = (|comb[i]) && ((hits & comb[i]) == comb[i]);

    // R8: an empty combination vector never fires
    p_empty_comb_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (comb[i] == '0) |=> !trig_o[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) trig_o <= '0;
    else        trig_o <= bus_valid ? fire : '0;
  end

  // R9: no bus cycle, no trigger on the next clock
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> (trig_o == '0));

endmodule

// File: rtl/bus_trig_bank.sv
module bus_trig_bank
  import bus_trig_pkg::*;
#(
  parameter int N_UNITS = 10,
  parameter int BUS_W   = 20,
  localparam int REG_AW = $clog2(N_UNITS * 8)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [BUS_W-1:0]    reg_wdata,
  output logic [BUS_W-1:0]    reg_rdata,
  input  logic                bus_valid,
  input  logic [BUS_W-1:0]    bus_addr,
  input  logic [BUS_W-1:0]    bus_data,
  input  logic                bus_fetch,
  input  logic                bus_hold,
  input  logic                bus_write,
  input  logic                bus_dma,
  output logic [N_UNITS-1:0]  trig_o
);
  logic [N_UNITS-1:0][BUS_W-1:0]   val;
  logic [N_UNITS-1:0][CTL_W-1:0]   ctl;
  logic [N_UNITS-1:0][BUS_W-1:0]   msk;
  logic [N_UNITS-1:0][N_UNITS-1:0] comb;
  logic [N_UNITS-1:0]              hits;

  btb_regs #(.N_UNITS(N_UNITS), .BUS_W(BUS_W), .AW(REG_AW)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .val_o(val), .ctl_o(ctl), .msk_o(msk), .comb_o(comb)
  );

  for (genvar i = 0; i < N_UNITS; i++) begin : g_match
    btb_match #(.BUS_W(BUS_W)) match_i (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_data(bus_data),
      .bus_fetch(bus_fetch), .bus_hold(bus_hold),
      .bus_write(bus_write), .bus_dma(bus_dma),
      .val(val[i]), .ctl(ctl[i]), .msk(msk[i]), .hit(hits[i])
    );
  end

  btb_combine #(.N_UNITS(N_UNITS)) comb_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid),
    .hits(hits), .comb(comb), .trig_o(trig_o)
  );

endmodule

// File: tb/bus_trig_bank_tb.sv
module bus_trig_bank_tb_top;
  localparam int N  = 10;
  localparam int BW = 20;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [BW-1:0] reg_wdata = '0;
  logic [BW-1:0] reg_rdata;
  logic          bus_valid = 1'b0;
  logic [BW-1:0] bus_addr = '0, bus_data = '0;
  logic          bus_fetch = 1'b0, bus_hold = 1'b0, bus_write = 1'b0, bus_dma = 1'b0;
  logic [N-1:0]  trig_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [BW-1:0] m_val [N];
  logic [6:0]    m_ctl [N];
  logic [BW-1:0] m_msk [N];
  logic [N-1:0]  m_comb[N];

  always #2 clk = ~clk;

  bus_trig_bank dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_fetch(bus_fetch),
    .bus_hold(bus_hold), .bus_write(bus_write), .bus_dma(bus_dma), .trig_o(trig_o)
  );

  function automatic bit mapped(logic [AW-1:0] a);
    return (a[0] == 1'b0) && (int'(a[AW-1:3]) < N);
  endfunction

  function automatic logic [BW-1:0] model_read(logic [AW-1:0] a);
    int u;
    u = int'(a[AW-1:3]);
    if (!mapped(a)) return '0;
    case (a[2:1])
      2'd0: return m_val[u];
      2'd1: return BW'(m_ctl[u]);
      2'd2: return m_msk[u];
      default: return BW'(m_comb[u]);
    endcase
  endfunction

  function automatic void model_write(logic [AW-1:0] a, logic [BW-1:0] d);
    int u;
    u = int'(a[AW-1:3]);
    if (!mapped(a)) return;
    case (a[2:1])
      2'd0: m_val[u] = d;
      2'd1: m_ctl[u] = d[6:0];
      2'd2: m_msk[u] = d;
      default: m_comb[u] = d[N-1:0];
    endcase
  endfunction

  function automatic bit kind_ok(logic [3:0] c, bit f, bit h, bit w, bit d);
    bit r;
    r = !w;
    case (c)
      4'd0:  return f;
      4'd1:  return h;
      4'd2:  return !f;
      4'd3:  return 1;
      4'd4:  return !f && r;
      4'd5:  return !f && w;
      4'd6:  return r;
      4'd7:  return w;
      4'd8:  return !f && !d;
      4'd9:  return d;
      4'd10: return !d;
      4'd11: return w && !d;
      4'd12: return !f && r && !d;
      4'd13: return r && !d;
      4'd14: return r && d;
      default: return w && d;
    endcase
  endfunction

  function automatic logic [N-1:0] model_fire(logic [BW-1:0] ba, logic [BW-1:0] bd,
                                              bit f, bit h, bit w, bit d);
    logic [N-1:0] hit;
    logic [N-1:0] res;
    for (int u = 0; u < N; u++) begin
      logic [BW-1:0] x, y;
      bit rel;
      x = (m_ctl[u][0] ? bd : ba) & ~m_msk[u];
      y = m_val[u] & ~m_msk[u];
      case (m_ctl[u][4:3])
        2'b00: rel = (x == y);
        2'b01: rel = (x > y);
        2'b10: rel = (x < y);
        default: rel = (x != y);
      endcase
      hit[u] = rel && kind_ok({m_ctl[u][6], m_ctl[u][5], m_ctl[u][2], m_ctl[u][1]}, f, h, w, d);
    end
    for (int u = 0; u < N; u++)
      res[u] = (m_comb[u] != '0) && ((hit & m_comb[u]) == m_comb[u]);
    return res;
  endfunction

  task automatic check(bit ok, string tag, logic [BW-1:0] act, logic [BW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%05h expected 0x%05h", tag, act, exp);
    end
  endtask

  // one clock: optional register write plus optional bus cycle, trigger checked after
  task automatic step(bit we, logic [AW-1:0] a, logic [BW-1:0] d, bit bv,
                      logic [BW-1:0] ba, logic [BW-1:0] bd, bit f, bit h, bit w, bit dm,
                      bit chk, string tag);
    logic [N-1:0] exp;
    reg_we = we; reg_addr = a; reg_wdata = d;
    bus_valid = bv; bus_addr = ba; bus_data = bd;
    bus_fetch = f; bus_hold = h; bus_write = w; bus_dma = dm;
    exp = bv ? model_fire(ba, bd, f, h, w, dm) : '0;
    @(negedge clk);
    if (we) model_write(a, d);
    reg_we = 0; bus_valid = 0;
    if (chk) check(trig_o == exp, tag, BW'(trig_o), BW'(exp));
  endtask

  task automatic wr(logic [AW-1:0] a, logic [BW-1:0] d);
    step(1, a, d, 0, '0, '0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic bus(logic [BW-1:0] ba, logic [BW-1:0] bd, bit f, bit h, bit w, bit dm, string tag);
    step(0, '0, '0, 1, ba, bd, f, h, w, dm, 1, tag);
  endtask

  task automatic rd(logic [AW-1:0] a, string tag);
    reg_addr = a;
    #1;
    check(reg_rdata == model_read(a), tag, reg_rdata, model_read(a));
  endtask

  task automatic unit_cfg(int u, logic [BW-1:0] v, logic [6:0] c, logic [BW-1:0] m, logic [N-1:0] cb);
    wr(AW'(u * 8 + 0), v);
    wr(AW'(u * 8 + 2), BW'(c));
    wr(AW'(u * 8 + 4), m);
    wr(AW'(u * 8 + 6), BW'(cb));
  endtask

  task automatic clear_all();
    for (int u = 0; u < N; u++) unit_cfg(u, '0, '0, '0, '0);
  endtask

  initial begin
    #(4ns * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    for (int u = 0; u < N; u++) begin
      m_val[u] = '0; m_ctl[u] = '0; m_msk[u] = '0; m_comb[u] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check(trig_o == '0, "R1 trig", BW'(trig_o), '0);
    for (int a = 0; a < N * 8; a += 2) rd(AW'(a), "R1 reg");

    // R2 map and widths
    wr(7'h18, 20'h12345); wr(7'h1A, 20'hFFFFF); wr(7'h1C, 20'hABCDE); wr(7'h1E, 20'hFFFFF);
    wr(7'h48, 20'h0F0F0); wr(7'h4E, 20'h00201);
    for (int a = 0; a < N * 8; a += 2) rd(AW'(a), "R2 readback");

    // R3 unmapped writes and reads
    wr(7'h50, 20'hABCDE); wr(7'h7E, 20'h11111); wr(7'h19, 20'h55555); wr(7'h01, 20'h77777);
    for (int a = 0; a < 128; a++) rd(AW'(a), "R3 unmapped");
    clear_all();

    // R4 bus select (code 3 = any access: ctl bits 2,1 set)
    unit_cfg(0, 20'h00ABC, 7'h06, '0, 10'h001);
    bus(20'h00ABC, 20'h00000, 0, 0, 0, 0, "R4 addr sel hit");
    bus(20'h00000, 20'h00ABC, 0, 0, 0, 0, "R4 addr sel miss");
    wr(7'h02, 20'h00007);
    bus(20'h00000, 20'h00ABC, 0, 0, 0, 0, "R4 data sel hit");
    bus(20'h00ABC, 20'h00000, 0, 0, 0, 0, "R4 data sel miss");

    // R5 relational modes
    for (int md = 0; md < 4; md++) begin
      wr(7'h02, BW'(7'h06 | 7'(md << 3)));
      bus(20'h00ABB, '0, 0, 0, 0, 0, "R5 below");
      bus(20'h00ABC, '0, 0, 0, 0, 0, "R5 equal");
      bus(20'h00ABD, '0, 0, 0, 0, 0, "R5 above");
      bus(20'hFFFFF, '0, 0, 0, 0, 0, "R5 top");
    end

    // R6 masks
    unit_cfg(0, 20'h12300, 7'h06, 20'h000FF, 10'h001);
    bus(20'h123FF, '0, 0, 0, 0, 0, "R6 low byte masked hit");
    bus(20'h12400, '0, 0, 0, 0, 0, "R6 low byte masked miss");
    unit_cfg(0, 20'h00F00, 7'h0E, 20'hF0000, 10'h001);
    bus(20'hF0000, '0, 0, 0, 0, 0, "R6 masked gt miss");
    bus(20'hF0F01, '0, 0, 0, 0, 0, "R6 masked gt hit");
    unit_cfg(0, 20'h12345, 7'h06, 20'hFFFFF, 10'h001);
    bus(20'h54321, '0, 0, 0, 0, 0, "R6 full mask");

    // R7 access codes, every code against every access kind
    for (int c = 0; c < 16; c++) begin
      logic [6:0] cw;
      cw = {c[3], c[2], 2'b00, c[1], c[0], 1'b0};
      unit_cfg(0, 20'h00100, cw, '0, 10'h001);
      for (int k = 0; k < 16; k++)
        bus(20'h00100, '0, k[0], k[1], k[2], k[3], "R7 access code");
    end
    clear_all();

    // R8 combinations
    unit_cfg(0, 20'h04000, 7'h06, '0, 10'h000);
    unit_cfg(1, 20'h000AA, 7'h07, '0, 10'h003);
    unit_cfg(2, 20'h00000, 7'h06, 20'hFFFFF, 10'h000);
    bus(20'h04000, 20'h000AA, 0, 0, 0, 0, "R8 both hit, empty vectors quiet");
    bus(20'h04000, 20'h000AB, 0, 0, 0, 0, "R8 one missing");
    bus(20'h04001, 20'h000AA, 0, 0, 0, 0, "R8 other missing");
    wr(7'h06, 20'h00002);
    bus(20'h04001, 20'h000AA, 0, 0, 0, 0, "R8 single unit");

    // R9 idle cycles
    step(0, '0, '0, 0, 20'h04000, 20'h000AA, 0, 0, 0, 0, 1, "R9 no bus cycle");
    bus(20'h04000, 20'h000AA, 0, 0, 0, 0, "R9 registered hit");
    step(0, '0, '0, 0, '0, '0, 0, 0, 0, 0, 1, "R9 drops after idle");

    // R10 write and bus cycle in the same clock
    step(1, 7'h08, 20'h00055, 1, 20'h04000, 20'h000AA, 0, 0, 0, 0, 1, "R10 old value used");
    bus(20'h04000, 20'h000AA, 0, 0, 0, 0, "R10 new value after");
    bus(20'h04000, 20'h00055, 0, 0, 0, 0, "R10 new value hit");

    // random mix
    for (int u = 0; u < N; u++) unit_cfg(u, BW'($urandom), 7'($urandom) | 7'h06, 20'hFF000, 10'(1 << u));
    for (int n = 0; n < 3000; n++) begin
      bit we;
      int u;
      logic [AW-1:0] a;
      logic [BW-1:0] d, ba, bd;
      we = ($urandom % 6) == 0;
      u  = int'($urandom % N);
      a  = AW'(u * 8 + 2 * int'($urandom % 4));
      case (a[2:1])
        2'd1: d = BW'($urandom);
        2'd2: case ($urandom % 5)
                0: d = 20'hFFFFF; 1: d = 20'hF0000; 2: d = 20'h0FF00;
                3: d = 20'h000FF; default: d = BW'($urandom);
              endcase
        2'd3: d = BW'((1 << ($urandom % N)) | (($urandom % 3 == 0) ? (1 << ($urandom % N)) : 0));
        default: d = BW'($urandom);
      endcase
      ba = ($urandom % 2) ? m_val[$urandom % N] ^ BW'($urandom % 4) : BW'($urandom);
      bd = ($urandom % 2) ? m_val[$urandom % N] : BW'($urandom);
      step(we, a, d, ($urandom % 8) != 0, ba, bd, 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 1, "R8 R10 random");
      if (n % 100 == 0) rd(AW'($urandom % 128), "R2 random readback");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule